// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block decides where an issuing load takes its data from when older stores are still waiting in the store queue. The load presents its byte address, byte size, its uncacheable attribute, its head and commit status, and its position in the store queue. The block scans the older stores and returns one of three outcomes. It can forward the bytes from a store that fully contains the load, send the load to memory, or send the load back for replay.

The store queue is a circular buffer of `DEPTH` entries, and `DEPTH` must be a power of two. The older stores are the entries from `sqHead` up to `ldSqIdx`, with `ldSqIdx` itself excluded. So at most `DEPTH-1` older stores can be seen by one load. The scan starts at the youngest older store and moves toward the oldest, and the first store that overlaps the load decides the result.

The queue contents, the cache and the replay scheduler sit outside the block and connect through plain ports. The result is registered and appears as a single-cycle strobe.

Top module: `stlf_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `resValid`, `resDefer`, `resClrIssued`, `resDecWb`, `resErrNoAddr` and `resErrDone` are all 0.
- R2: Each cycle with `ldValid` high produces exactly one cycle of `resValid` high on the next clock edge. When `ldValid` is low, `resValid` is low one edge later.
- R3: Only entries in the circular range from `sqHead` up to `ldSqIdx`, excluding `ldSqIdx`, are searched. The search begins at entry `ldSqIdx-1` and moves toward `sqHead`. The first overlapping store that is eligible decides the outcome.
- R4: A valid store whose size field `stSize` is 0 is skipped by the search. Sizes are byte counts: 0, 1, 2, 4 or 8.
- R5: A valid store whose `stUncache` bit is set is skipped by the search.
- R6: A store that covers every byte of the load gives `resKind` = 0 (FORWARD) and `resIdx` equal to that entry. `resData` is the store data shifted right by 8×(`ldAddr` AND (`stSize`−1)) bits. All bytes at or above the load size are zero.
- R7: A store that overlaps the load only partly gives `resKind` = 2 (REPLAY) with `resIdx` equal to that entry. It also raises `resClrIssued` and `resDecWb`.
- R8: If no eligible store overlaps the load, the result is `resKind` = 1 (MEMORY).
- R9: An uncacheable load that is not both at the head (`ldAtHead`) and at commit (`ldAtCommit`) gets `resKind` = 2 with `resDefer` = 1 and `resClrIssued` = 0, and no search is run. An uncacheable load that is at both the head and commit is searched like any other load.
- R10: `resErrNoAddr` is raised when a searched entry is valid, has a nonzero size, is cacheable and has `stAddrValid` low. Such an entry never matches.
- R11: `resErrDone` is raised when any valid entry in the searched range has its `stDone` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ldValid | input | 1 | Load issue request |
| ldAddr | input | AW | Load byte address |
| ldSize | input | SZW | Load size in bytes (1, 2, 4, 8) |
| ldUncache | input | 1 | Load is uncacheable |
| ldAtHead | input | 1 | Load is at load-queue head |
| ldAtCommit | input | 1 | Load is at commit |
| ldSqIdx | input | IW | Store-queue slot after the load's youngest older store |
| sqHead | input | IW | Oldest store-queue slot |
| stValid | input | DEPTH | Entry holds a store |
| stAddrValid | input | DEPTH | Entry address is known |
| stUncache | input | DEPTH | Entry is uncacheable |
| stDone | input | DEPTH | Entry already written back |
| stAddr | input | DEPTH*AW | Entry addresses, entry i at bits i*AW |
| stSize | input | DEPTH*SZW | Entry sizes in bytes |
| stData | input | DEPTH*DW | Entry data, byte 0 in low bits |
| resValid | output | 1 | Result strobe |
| resKind | output | 2 | 0 FORWARD, 1 MEMORY, 2 REPLAY |
| resIdx | output | IW | Matched store entry |
| resData | output | DW | Forwarded data, right-justified |
| resDefer | output | 1 | Uncacheable load deferred |
| resClrIssued | output | 1 | Clear load's issued flag |
| resDecWb | output | 1 | Decrement pending writeback count |
| resErrNoAddr | output | 1 | Eligible store lacked an address |
| resErrDone | output | 1 | Completed store seen in range |

## Verification
All outcomes, data and error flags are decided combinationally and are captured by one register stage, so every result is due exactly one clock edge after the cycle in which `ldValid` was high. The bench drives the load and the queue contents on a falling edge and holds them stable through the next rising edge. It then compares all outputs on the following falling edge, with the queue unchanged, so each sample falls midway between the capture edge and the next one. Idle checks are made one falling edge later still, to confirm that the strobe has dropped.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
  typedef enum logic [1:0] {
    KIND_FWD    = 2'd0,
    KIND_MEM    = 2'd1,
    KIND_REPLAY = 2'd2
  } resKind_e;

  typedef struct packed {
    logic go;
    logic fwd;
    logic part;
    logic defer;
    logic errNoAddr;
    logic errDone;
  } ctrlStrobe_t;
endpackage

// File: rtl/stlf_ctrl.sv
module stlf_ctrl
  import stlf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DW / 8),
  localparam int SZW  = OW + 1
) (
  input  logic                 ldValid,
  input  logic [AW-1:0]        ldAddr,
  input  logic [SZW-1:0]       ldSize,
  input  logic                 ldUncache,
  input  logic                 ldAtHead,
  input  logic                 ldAtCommit,
  input  logic [IW-1:0]        ldSqIdx,
  input  logic [IW-1:0]        sqHead,
  input  logic [DEPTH-1:0]     stValid,
  input  logic [DEPTH-1:0]     stAddrValid,
  input  logic [DEPTH-1:0]     stUncache,
  input  logic [DEPTH-1:0]     stDone,
  input  logic [DEPTH*AW-1:0]  stAddr,
  input  logic [DEPTH*SZW-1:0] stSize,
  output ctrlStrobe_t          strobe,
  output logic [IW-1:0]        matchIdx,
  output logic [OW-1:0]        byteOff
);
  logic [IW-1:0]  olderCnt;
  logic [IW-1:0]  idx;
  logic [SZW-1:0] sz;
  logic [SZW-1:0] szM1;
  logic [AW:0]    ldLo, ldHi, stLo, stHi;
  logic           found, fwdHit, partHit, noAddr, doneSeen, defer, go;

  assign defer = ldValid && ldUncache && !(ldAtHead && ldAtCommit);
  assign go    = ldValid && !defer;

  always_comb begin
    olderCnt = ldSqIdx - sqHead;
    ldLo     = {1'b0, ldAddr};
    ldHi     = ldLo + (AW+1)'(ldSize);
    found    = 1'b0;
    fwdHit   = 1'b0;
    partHit  = 1'b0;
    noAddr   = 1'b0;
    doneSeen = 1'b0;
    matchIdx = '0;
    byteOff  = '0;
    idx      = '0;
    sz       = '0;
    szM1     = '0;
    stLo     = '0;
    stHi     = '0;
    // youngest older store first, walking back toward the queue head
    for (int k = 0; k < DEPTH; k++) begin
      idx  = ldSqIdx - IW'(k + 1);
      sz   = stSize[idx*SZW +: SZW];
      szM1 = sz - SZW'(1);
      stLo = {1'b0, stAddr[idx*AW +: AW]};
      stHi = stLo + (AW+1)'(sz);
      if (k < int'(olderCnt) && stValid[idx]) begin
        if (stDone[idx]) doneSeen = 1'b1;
        if (sz != '0 && !stUncache[idx]) begin
          if (!stAddrValid[idx]) begin
            noAddr = 1'b1;
          end else if (!found) begin
            if (stLo <= ldLo && ldHi <= stHi) begin
              found    = 1'b1;
              fwdHit   = 1'b1;
              matchIdx = idx;
              byteOff  = ldAddr[OW-1:0] & szM1[OW-1:0];
            end else if (ldLo < stHi && stLo < ldHi) begin
              found    = 1'b1;
              partHit  = 1'b1;
              matchIdx = idx;
            end
          end
        end
      end
    end
    strobe.go        = go;
    strobe.defer     = defer;
    strobe.fwd       = go && fwdHit;
    strobe.part      = go && partHit;
    strobe.errNoAddr = go && noAddr;
    strobe.errDone   = go && doneSeen;
  end
endmodule

// File: rtl/stlf_datapath.sv
module stlf_datapath
  import stlf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DW / 8),
  localparam int SZW  = OW + 1,
  localparam int NB   = DW / 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ldValid,
  input  logic [SZW-1:0]      ldSize,
  input  logic [DEPTH*DW-1:0] stData,
  input  ctrlStrobe_t         strobe,
  input  logic [IW-1:0]       matchIdx,
  input  logic [OW-1:0]       byteOff,
  output logic                resValid,
  output logic [1:0]          resKind,
  output logic [IW-1:0]       resIdx,
  output logic [DW-1:0]       resData,
  output logic                resDefer,
  output logic                resClrIssued,
  output logic                resDecWb,
  output logic                resErrNoAddr,
  output logic                resErrDone
);
  logic [DW-1:0] selData, shifted, byteMask, fwdData;
  logic [1:0]    kindNext;

  assign selData = stData[matchIdx*DW +: DW];
  assign shifted = selData >> {byteOff, 3'b000};

  always_comb begin
    for (int b = 0; b < NB; b++)
      byteMask[b*8 +: 8] = (b < int'(ldSize)) ? 8'hFF : 8'h00;
  end

  assign fwdData = shifted & byteMask;

  always_comb begin
    if (strobe.defer || strobe.part) kindNext = KIND_REPLAY;
    else if (strobe.fwd)             kindNext = KIND_FWD;
    else                             kindNext = KIND_MEM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid     <= 1'b0;
      resKind      <= KIND_MEM;
      resIdx       <= '0;
      resData      <= '0;
      resDefer     <= 1'b0;
      resClrIssued <= 1'b0;
      resDecWb     <= 1'b0;
      resErrNoAddr <= 1'b0;
      resErrDone   <= 1'b0;
    end else begin
      resValid     <= ldValid;
      resKind      <= ldValid ? kindNext : KIND_MEM;
      resIdx       <= (strobe.fwd || strobe.part) ? matchIdx : '0;
      resData      <= strobe.fwd ? fwdData : '0;
      resDefer     <= strobe.defer;
      resClrIssued <= strobe.part;
      resDecWb     <= strobe.part;
      resErrNoAddr <= strobe.errNoAddr;
      resErrDone   <= strobe.errDone;
    end
  end

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    ldValid |=> resValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !ldValid |=> !resValid);
  // R7
  replay_clear_kind_chk: assert property (@(posedge clk) disable iff (rst)
    resClrIssued |-> (resValid && resKind == KIND_REPLAY && !resDefer && resDecWb));
  // R9
  defer_kind_chk: assert property (@(posedge clk) disable iff (rst)
    resDefer |-> (resValid && resKind == KIND_REPLAY && !resClrIssued));
  // R6
  fwd_byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resKind == KIND_FWD && $past(ldSize) == SZW'(1)) |-> resData[DW-1:8] == '0);
  // R8
  legal_kind_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> resKind != 2'd3);
endmodule

// File: rtl/stlf_top.sv
module stlf_top
  import stlf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DW / 8),
  localparam int SZW  = OW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ldValid,
  input  logic [AW-1:0]        ldAddr,
  input  logic [SZW-1:0]       ldSize,
  input  logic                 ldUncache,
  input  logic                 ldAtHead,
  input  logic                 ldAtCommit,
  input  logic [IW-1:0]        ldSqIdx,
  input  logic [IW-1:0]        sqHead,
  input  logic [DEPTH-1:0]     stValid,
  input  logic [DEPTH-1:0]     stAddrValid,
  input  logic [DEPTH-1:0]     stUncache,
  input  logic [DEPTH-1:0]     stDone,
  input  logic [DEPTH*AW-1:0]  stAddr,
  input  logic [DEPTH*SZW-1:0] stSize,
  input  logic [DEPTH*DW-1:0]  stData,
  output logic                 resValid,
  output logic [1:0]           resKind,
  output logic [IW-1:0]        resIdx,
  output logic [DW-1:0]        resData,
  output logic                 resDefer,
  output logic                 resClrIssued,
  output logic                 resDecWb,
  output logic                 resErrNoAddr,
  output logic                 resErrDone
);
  ctrlStrobe_t   strobe;
  logic [IW-1:0] matchIdx;
  logic [OW-1:0] byteOff;

  stlf_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_ctrl (
    .ldValid(ldValid), .ldAddr(ldAddr), .ldSize(ldSize), .ldUncache(ldUncache),
    .ldAtHead(ldAtHead), .ldAtCommit(ldAtCommit), .ldSqIdx(ldSqIdx), .sqHead(sqHead),
    .stValid(stValid), .stAddrValid(stAddrValid), .stUncache(stUncache), .stDone(stDone),
    .stAddr(stAddr), .stSize(stSize),
    .strobe(strobe), .matchIdx(matchIdx), .byteOff(byteOff)
  );

  stlf_datapath #(.DEPTH(DEPTH), .DW(DW)) i_datapath (
    .clk(clk), .rst(rst), .ldValid(ldValid), .ldSize(ldSize), .stData(stData),
    .strobe(strobe), .matchIdx(matchIdx), .byteOff(byteOff),
    .resValid(resValid), .resKind(resKind), .resIdx(resIdx), .resData(resData),
    .resDefer(resDefer), .resClrIssued(resClrIssued), .resDecWb(resDecWb),
    .resErrNoAddr(resErrNoAddr), .resErrDone(resErrDone)
  );
endmodule

// File: tb/test_stlf_top.sv
module test_stlf_top;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int IW = 3;
  localparam int SZW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           ldValid = 0, ldUncache = 0, ldAtHead = 0, ldAtCommit = 0;
  logic [AW-1:0]  ldAddr = 0;
  logic [SZW-1:0] ldSize = 1;
  logic [IW-1:0]  ldSqIdx = 0, sqHead = 0;
  logic [D-1:0]   tValid = 0, tAddrValid = 0, tUnc = 0, tDone = 0;
  logic [AW-1:0]  tAddr [D];
  logic [SZW-1:0] tSize [D];
  logic [DW-1:0]  tData [D];
  logic [D*AW-1:0]  stAddrF;
  logic [D*SZW-1:0] stSizeF;
  logic [D*DW-1:0]  stDataF;

  always_comb begin
    for (int i = 0; i < D; i++) begin
      stAddrF[i*AW +: AW]   = tAddr[i];
      stSizeF[i*SZW +: SZW] = tSize[i];
      stDataF[i*DW +: DW]   = tData[i];
    end
  end

  logic          resValid, resDefer, resClrIssued, resDecWb, resErrNoAddr, resErrDone;
  logic [1:0]    resKind;
  logic [IW-1:0] resIdx;
  logic [DW-1:0] resData;

  stlf_top i_stlf_top (
    .clk(clk), .rst(rst), .ldValid(ldValid), .ldAddr(ldAddr), .ldSize(ldSize),
    .ldUncache(ldUncache), .ldAtHead(ldAtHead), .ldAtCommit(ldAtCommit),
    .ldSqIdx(ldSqIdx), .sqHead(sqHead), .stValid(tValid), .stAddrValid(tAddrValid),
    .stUncache(tUnc), .stDone(tDone), .stAddr(stAddrF), .stSize(stSizeF), .stData(stDataF),
    .resValid(resValid), .resKind(resKind), .resIdx(resIdx), .resData(resData),
    .resDefer(resDefer), .resClrIssued(resClrIssued), .resDecWb(resDecWb),
    .resErrNoAddr(resErrNoAddr), .resErrDone(resErrDone)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [1:0]    eKind;
  logic [IW-1:0] eIdx;
  logic [DW-1:0] eData;
  logic          eDefer, eClr, eNoAddr, eDone;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected outcome from the requirements
  task automatic expModel();
    int cnt;
    bit found;
    eKind = 2'd1; eIdx = 0; eData = 0; eDefer = 0; eClr = 0; eNoAddr = 0; eDone = 0;
    if (ldUncache && !(ldAtHead && ldAtCommit)) begin
      eKind = 2'd2; eDefer = 1;  // R9
      return;
    end
    cnt = (int'(ldSqIdx) - int'(sqHead) + D) % D;
    found = 0;
    for (int k = 0; k < cnt; k++) begin
      int i;
      longint lLo, lHi, sLo, sHi;
      i = (int'(ldSqIdx) - 1 - k + 2*D) % D;
      if (!tValid[i]) continue;
      if (tDone[i]) eDone = 1;
      if (tSize[i] == 0 || tUnc[i]) continue;
      if (!tAddrValid[i]) begin eNoAddr = 1; continue; end
      if (found) continue;
      lLo = longint'(ldAddr); lHi = lLo + longint'(ldSize);
      sLo = longint'(tAddr[i]); sHi = sLo + longint'(tSize[i]);
      if (sLo <= lLo && lHi <= sHi) begin
        int off;
        logic [DW-1:0] v;
        off = int'(ldAddr & AW'(tSize[i] - 1)) & 7;
        v = tData[i] >> (8*off);
        for (int b = 0; b < 8; b++) if (b >= int'(ldSize)) v[b*8 +: 8] = 8'h00;
        found = 1; eKind = 2'd0; eIdx = IW'(i); eData = v;
      end else if (lLo < sHi && sLo < lHi) begin
        found = 1; eKind = 2'd2; eIdx = IW'(i); eClr = 1;
      end
    end
  endtask

  task automatic doLoad(string tag, logic [AW-1:0] a, logic [SZW-1:0] s,
                        logic unc, logic hd, logic cm);
    ldAddr = a; ldSize = s; ldUncache = unc; ldAtHead = hd; ldAtCommit = cm;
    ldValid = 1;
    expModel();
    @(negedge clk);
    ldValid = 0;
    chk({tag, " R2 valid"}, 64'(resValid), 64'd1);
    chk({tag, " kind"}, 64'(resKind), 64'(eKind));
    chk({tag, " R9 defer"}, 64'(resDefer), 64'(eDefer));
    chk({tag, " R7 clr"}, 64'({resClrIssued, resDecWb}), 64'({eClr, eClr}));
    chk({tag, " R10 noaddr"}, 64'(resErrNoAddr), 64'(eNoAddr));
    chk({tag, " R11 done"}, 64'(resErrDone), 64'(eDone));
    if (eKind == 2'd0 || eClr) chk({tag, " R3 idx"}, 64'(resIdx), 64'(eIdx));
    if (eKind == 2'd0) chk({tag, " R6 data"}, resData, eData);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk("R2 idle", 64'(resValid), 64'd0);
  endtask

  task automatic clearQ();
    tValid = 0; tAddrValid = 0; tUnc = 0; tDone = 0;
    for (int i = 0; i < D; i++) begin tAddr[i] = 0; tSize[i] = 0; tData[i] = 0; end
  endtask

  task automatic setSt(int i, logic [AW-1:0] a, logic [SZW-1:0] s, logic [DW-1:0] d);
    tValid[i] = 1; tAddrValid[i] = 1; tUnc[i] = 0; tDone[i] = 0;
    tAddr[i] = a; tSize[i] = s; tData[i] = d;
  endtask

  function automatic logic [SZW-1:0] pickSize(int r);
    case (r % 4)
      0: return 4'd1;
      1: return 4'd2;
      2: return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    clearQ();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset valid", 64'({resValid, resDefer, resClrIssued, resDecWb, resErrNoAddr, resErrDone}), 64'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", 64'({resValid, resDefer, resClrIssued, resDecWb, resErrNoAddr, resErrDone}), 64'd0);

    // R3 R8: empty range even though a matching store sits elsewhere
    setSt(3, 32'h100, 4'd8, 64'h1111);
    sqHead = 2; ldSqIdx = 2;
    doLoad("R8 empty range", 32'h100, 4'd4, 0, 0, 0);
    idleCheck();

    // R6: full forward with byte offset
    clearQ(); sqHead = 0; ldSqIdx = 3;
    setSt(2, 32'h100, 4'd8, 64'h8877665544332211);
    doLoad("R6 fwd offset", 32'h102, 4'd2, 0, 0, 0);
    chk("R6 data 4433", resData, 64'h4433);

    // R3: youngest wins
    setSt(1, 32'h100, 4'd8, 64'hAAAAAAAAAAAAAAAA);
    setSt(2, 32'h100, 4'd4, 64'h00000000BBBBBBBB);
    doLoad("R3 youngest", 32'h100, 4'd4, 0, 0, 0);
    chk("R3 youngest idx", 64'(resIdx), 64'd2);

    // R4: zero-size skipped
    tSize[2] = 0;
    doLoad("R4 zero size", 32'h100, 4'd4, 0, 0, 0);
    chk("R4 falls to older", 64'(resIdx), 64'd1);

    // R5: uncacheable store skipped
    tSize[2] = 4; tUnc[2] = 1;
    doLoad("R5 unc store", 32'h100, 4'd4, 0, 0, 0);
    chk("R5 data", resData, 64'hAAAAAAAA);

    // R7: partial overlap
    clearQ(); setSt(2, 32'h104, 4'd4, 64'h5);
    doLoad("R7 partial", 32'h100, 4'd8, 0, 0, 0);
    chk("R7 kind replay", 64'(resKind), 64'd2);

    // R9: deferral and head+commit search
    clearQ(); setSt(2, 32'h100, 4'd8, 64'h0123456789ABCDEF);
    doLoad("R9 not commit", 32'h100, 4'd8, 1, 1, 0);
    chk("R9 defer flag", 64'(resDefer), 64'd1);
    doLoad("R9 not head", 32'h100, 4'd8, 1, 0, 1);
    doLoad("R9 head commit", 32'h100, 4'd8, 1, 1, 1);
    chk("R9 searched kind", 64'(resKind), 64'd0);

    // R10: missing address
    setSt(1, 32'h100, 4'd8, 64'h77);
    tAddrValid[2] = 0;
    doLoad("R10 noaddr", 32'h100, 4'd1, 0, 0, 0);
    chk("R10 flag", 64'(resErrNoAddr), 64'd1);

    // R11: completed store in range
    tAddrValid[2] = 1; tDone[1] = 1;
    doLoad("R11 done", 32'h100, 4'd1, 0, 0, 0);
    chk("R11 flag", 64'(resErrDone), 64'd1);

    // R3: wrap-around range, entry outside range ignored
    clearQ(); sqHead = 6; ldSqIdx = 1;
    setSt(3, 32'h200, 4'd8, 64'hDEAD);
    setSt(7, 32'h200, 4'd8, 64'h00000000CAFEF00D);
    setSt(0, 32'h300, 4'd8, 64'h1);
    doLoad("R3 wrap", 32'h200, 4'd4, 0, 0, 0);
    chk("R3 wrap idx", 64'(resIdx), 64'd7);
    idleCheck();

    // random mix
    for (int n = 0; n < 400; n++) begin
      clearQ();
      for (int i = 0; i < D; i++) begin
        logic [SZW-1:0] s;
        if ($urandom % 4 == 0) continue;
        s = ($urandom % 8 == 0) ? 4'd0 : pickSize(int'($urandom));
        setSt(i, (32'h200 + ($urandom % 32)) & ~(32'(s == 0 ? 1 : s) - 1), s,
              {$urandom, $urandom});
        tUnc[i] = ($urandom % 8 == 0);
      end
      sqHead  = IW'($urandom);
      ldSqIdx = IW'($urandom);
      begin
        logic [SZW-1:0] ls;
        ls = pickSize(int'($urandom));
        doLoad("R8 random", (32'h200 + ($urandom % 32)) & ~(32'(ls) - 1), ls,
               ($urandom % 8 == 0), 1'($urandom), 1'($urandom));
      end
      if (n % 16 == 0) idleCheck();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule